// File: doc/BRIEF.md
# Dual-Processor Sync Doorbell Register

This block holds one 32-bit sync register for each of two processors, A and B. Each processor has its own register port with a write enable, four byte-lane strobes, write data and combinational read data. Each side keeps an 8-bit outgoing byte. The other side reads that byte in the low byte of its own register, so the two processors can pass a small status value without a mailbox.

Each side can also ring a doorbell toward either processor by writing 1 to one of two trigger bits in its top byte. The block drives one interrupt output per processor. That output is gated by the target processor's own enable bit. It is a pulse one clock long, and it rises in the cycle after the triggering write.

Top module: `sync_doorbell`

## Requirements
- R1: After reset both outgoing bytes and both enable bits are 0, both read words are 0 and both interrupt outputs are low.
- R2: A write from side A with strobe bit 1 set stores wdata[15:8] as A's outgoing byte. From the next cycle on, A reads it back in bits 15:8 and B reads it in bits 7:0.
- R3: A write from side B with strobe bit 1 set stores wdata[15:8] as B's outgoing byte. From the next cycle on, B reads it back in bits 15:8 and A reads it in bits 7:0.
- R4: Bits 7:0 of either register are read-only. A write that strobes only lane 0 changes no read value and raises no interrupt.
- R5: Bit 31 is each side's own interrupt enable. A write with strobe bit 3 set loads it from wdata[31], and it reads back in bit 31.
- R6: A write from either side with strobe bit 3 set and wdata[30]=1 raises irq_a in the next cycle. This happens only if A's enable was 1 before that write, so a write that clears A's enable while it triggers still fires.
- R7: A write from either side with strobe bit 3 set and wdata[29]=1 raises irq_b in the next cycle. This happens only if B's enable was 1 before that write.
- R8: A trigger toward a processor whose enable is 0 raises no interrupt, and writing 0 to bits 29 and 30 raises none.
- R9: Bits 29 and 30 always read as 0. Bits 30:16 read as 0 and ignore writes.
- R10: A lane whose strobe bit is clear is not written. Trigger and enable bits in wdata have no effect without strobe bit 3, and the outgoing byte has no effect without strobe bit 1.
- R11: Each interrupt is a single-cycle pulse. When both sides trigger the same processor in one cycle, that processor gets one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write enable |
| a_wstrb | input | 4 | Side A byte-lane strobes |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read word |
| b_wr | input | 1 | Side B write enable |
| b_wstrb | input | 4 | Side B byte-lane strobes |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read word |
| irq_a | output | 1 | Sync interrupt pulse to processor A |
| irq_b | output | 1 | Sync interrupt pulse to processor B |

## Verification
The doorbell is rung in several ways: by the owning side and by the remote side, toward each processor, and by both sides at once. It is also rung with the target's enable off, and by a write that clears the enable while it triggers. These cases separate the enable gating and its timing from the trigger decode, and they show whether simultaneous triggers merge into one pulse. Byte exchange is tried with full, partial and missing strobes, so that a lane decode error shows up as a changed read word. A write of all ones checks that the reserved and trigger bits read back as zero.

// File: rtl/sync_doorbell_pkg.sv
package sync_doorbell_pkg;
  localparam int REG_W      = 32;
  localparam int LANE_W     = 8;
  localparam int LANES      = REG_W / LANE_W;
  localparam int TX_LANE    = 1;
  localparam int CTL_LANE   = 3;
  localparam int TRIG_B_BIT = 29;
  localparam int TRIG_A_BIT = 30;
  localparam int EN_BIT     = 31;
  localparam int RESV_W     = REG_W - 1 - 2 * LANE_W;

  // Read word: enable on top, reserved zeros, own outgoing byte, remote byte.
  function automatic logic [REG_W-1:0] pack_sync_word(
    input logic              en,
    input logic [LANE_W-1:0] own_tx,
    input logic [LANE_W-1:0] remote_tx
  );
    return {en, {RESV_W{1'b0}}, own_tx, remote_tx};
  endfunction

  // One-hot trigger decode for a control-lane write.
  function automatic logic ring_hit(
    input logic             wr,
    input logic [LANES-1:0] strb,
    input logic [REG_W-1:0] data,
    input int               bit_pos
  );
    return wr & strb[CTL_LANE] & data[bit_pos];
  endfunction
endpackage

// File: rtl/sync_side_reg.sv
module sync_side_reg
  import sync_doorbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LANES-1:0]  wstrb,
  input  logic [REG_W-1:0]  wdata,
  output logic [LANE_W-1:0] tx_byte,
  output logic              irq_en,
  output logic              ring_a,
  output logic              ring_b
);
  logic tx_we, ctl_we;
  logic unused_wdata_bits;

  assign tx_we  = wr & wstrb[TX_LANE];
  assign ctl_we = wr & wstrb[CTL_LANE];
  assign ring_a = ring_hit(wr, wstrb, wdata, TRIG_A_BIT);
  assign ring_b = ring_hit(wr, wstrb, wdata, TRIG_B_BIT);
  assign unused_wdata_bits = ^{wdata[LANE_W-1:0], wdata[TRIG_B_BIT-1:2*LANE_W], wstrb[0], wstrb[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_byte <= '0;
      irq_en  <= 1'b0;
    end else begin
      if (tx_we)  tx_byte <= wdata[TX_LANE*LANE_W +: LANE_W];
      if (ctl_we) irq_en  <= wdata[EN_BIT];
    end
  end

  // R10: outgoing byte moves only on a lane-1 write
  p_tx_lane_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && wstrb[TX_LANE]) |=> $stable(tx_byte));
  // R10: enable moves only on a lane-3 write
  p_en_lane_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && wstrb[CTL_LANE]) |=> $stable(irq_en));
endmodule

// File: rtl/sync_irq_gate.sv
module sync_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_from_a,
  input  logic ring_from_b,
  input  logic irq_en,
  output logic irq_out
);
  logic ring_any;
  assign ring_any = ring_from_a | ring_from_b;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= ring_any & irq_en;
  end

  // R8: a disabled target never pulses
  p_no_irq_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_out);
  // R11: no ring means the pulse drops
  p_pulse_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_from_a && !ring_from_b |=> !irq_out);
endmodule

// File: rtl/sync_doorbell.sv
module sync_doorbell
  import sync_doorbell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_wr,
  input  logic [LANES-1:0] a_wstrb,
  input  logic [REG_W-1:0] a_wdata,
  output logic [REG_W-1:0] a_rdata,
  input  logic             b_wr,
  input  logic [LANES-1:0] b_wstrb,
  input  logic [REG_W-1:0] b_wdata,
  output logic [REG_W-1:0] b_rdata,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int SIDES = 2;

  logic [LANE_W-1:0] tx_byte [SIDES];
  logic [SIDES-1:0]  en_q;
  logic [SIDES-1:0]  ring_to_a;   // indexed by source side
  logic [SIDES-1:0]  ring_to_b;
  logic [SIDES-1:0]  side_wr;
  logic [LANES-1:0]  side_strb [SIDES];
  logic [REG_W-1:0]  side_data [SIDES];

  assign side_wr      = {b_wr, a_wr};
  assign side_strb[0] = a_wstrb;
  assign side_strb[1] = b_wstrb;
  assign side_data[0] = a_wdata;
  assign side_data[1] = b_wdata;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    sync_side_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (side_wr[s]),
      .wstrb   (side_strb[s]),
      .wdata   (side_data[s]),
      .tx_byte (tx_byte[s]),
      .irq_en  (en_q[s]),
      .ring_a  (ring_to_a[s]),
      .ring_b  (ring_to_b[s])
    );
  end

  assign a_rdata = pack_sync_word(en_q[0], tx_byte[0], tx_byte[1]);
  assign b_rdata = pack_sync_word(en_q[1], tx_byte[1], tx_byte[0]);

  sync_irq_gate u_gate_a (
    .clk(clk), .rst_n(rst_n),
    .ring_from_a(ring_to_a[0]), .ring_from_b(ring_to_a[1]),
    .irq_en(en_q[0]), .irq_out(irq_a)
  );

  sync_irq_gate u_gate_b (
    .clk(clk), .rst_n(rst_n),
    .ring_from_a(ring_to_b[0]), .ring_from_b(ring_to_b[1]),
    .irq_en(en_q[1]), .irq_out(irq_b)
  );

  // R2: A's outgoing byte lands in B's low byte
  p_cross_a_to_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_wstrb[TX_LANE]) |=> b_rdata[LANE_W-1:0] == $past(a_wdata[2*LANE_W-1:LANE_W]));
  // R3: B's outgoing byte lands in A's low byte
  p_cross_b_to_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && b_wstrb[TX_LANE]) |=> a_rdata[LANE_W-1:0] == $past(b_wdata[2*LANE_W-1:LANE_W]));
  // R5: enable loads from a control-lane write
  p_enable_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_wstrb[CTL_LANE]) |=> a_rdata[EN_BIT] == $past(a_wdata[EN_BIT]));
  // R6: an A pulse needs a bit-30 trigger and A enabled
  p_irq_a_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> $past(a_rdata[EN_BIT]) &&
      $past((a_wr && a_wstrb[CTL_LANE] && a_wdata[TRIG_A_BIT]) ||
            (b_wr && b_wstrb[CTL_LANE] && b_wdata[TRIG_A_BIT])));
  // R7: a B pulse needs a bit-29 trigger and B enabled
  p_irq_b_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> $past(b_rdata[EN_BIT]) &&
      $past((a_wr && a_wstrb[CTL_LANE] && a_wdata[TRIG_B_BIT]) ||
            (b_wr && b_wstrb[CTL_LANE] && b_wdata[TRIG_B_BIT])));
endmodule

// File: tb/sync_doorbell_test.sv
module sync_doorbell_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_wr, b_wr;
  logic [3:0]  a_wstrb, b_wstrb;
  logic [31:0] a_wdata, b_wdata;
  logic [31:0] a_rdata, b_rdata;
  logic        irq_a, irq_b;

  always #5 clk = ~clk;

  sync_doorbell uut (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_wstrb(a_wstrb), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_wstrb(b_wstrb), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  typedef struct {
    int          due;
    string       req;
    logic [31:0] ra, rb;
    logic        ia, ib;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  // bench model
  logic [7:0] m_tx_a = 8'h00, m_tx_b = 8'h00;
  logic       m_en_a = 1'b0, m_en_b = 1'b0;

  function automatic logic [31:0] word(logic en, logic [7:0] own, logic [7:0] rem);
    logic [31:0] w;
    w = 32'h0;
    w[31] = en;
    w[15:8] = own;
    w[7:0] = rem;
    return w;
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // monitor: compare due items at each falling edge
  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      check32(e.req, "a_rdata", a_rdata, e.ra);
      check32(e.req, "b_rdata", b_rdata, e.rb);
      check32(e.req, "irq_a", {31'b0, irq_a}, {31'b0, e.ia});
      check32(e.req, "irq_b", {31'b0, irq_b}, {31'b0, e.ib});
    end
  end

  // driver: one write cycle then one idle cycle, expectations queued for both
  task automatic op(input bit aw, input logic [3:0] as, input logic [31:0] ad,
                    input bit bw, input logic [3:0] bs, input logic [31:0] bd,
                    input string req);
    exp_t e;
    logic ia, ib;
    @(negedge clk); #1;
    a_wr = aw; a_wstrb = as; a_wdata = ad;
    b_wr = bw; b_wstrb = bs; b_wdata = bd;
    ia = m_en_a & ((aw & as[3] & ad[30]) | (bw & bs[3] & bd[30]));
    ib = m_en_b & ((aw & as[3] & ad[29]) | (bw & bs[3] & bd[29]));
    if (aw && as[1]) m_tx_a = ad[15:8];
    if (aw && as[3]) m_en_a = ad[31];
    if (bw && bs[1]) m_tx_b = bd[15:8];
    if (bw && bs[3]) m_en_b = bd[31];
    e.due = cyc + 1; e.req = req;
    e.ra = word(m_en_a, m_tx_a, m_tx_b);
    e.rb = word(m_en_b, m_tx_b, m_tx_a);
    e.ia = ia; e.ib = ib;
    q.push_back(e);
    e.due = cyc + 2; e.req = {req, "/R11"};
    e.ia = 1'b0; e.ib = 1'b0;
    q.push_back(e);
    @(negedge clk); #1;
    a_wr = 0; b_wr = 0; a_wstrb = '0; b_wstrb = '0; a_wdata = '0; b_wdata = '0;
    @(negedge clk); #1;
  endtask

  task automatic op_a(input logic [3:0] s, input logic [31:0] d, input string req);
    op(1, s, d, 0, 4'h0, 32'h0, req);
  endtask

  task automatic op_b(input logic [3:0] s, input logic [31:0] d, input string req);
    op(0, 4'h0, 32'h0, 1, s, d, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; a_wr = 0; b_wr = 0; a_wstrb = '0; b_wstrb = '0; a_wdata = '0; b_wdata = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    op(0, 4'h0, 32'h0, 0, 4'h0, 32'h0, "R1");            // reset state
    op_a(4'b0010, 32'h0000_5A00, "R2");                  // A outgoing byte
    op_b(4'b0010, 32'h0000_C300, "R3");                  // B outgoing byte
    op_a(4'b0001, 32'hFFFF_FFFF, "R4");                  // read-only low lane
    op_a(4'b0010, 32'hFFFF_A5FF, "R10");                 // only lane 1 takes
    op_a(4'b1000, 32'h4000_0000, "R8");                  // trigger A while disabled
    op_a(4'b1000, 32'h8000_0000, "R5");                  // enable A
    op_b(4'b1000, 32'h8000_0000, "R5");                  // enable B
    op_a(4'b1000, 32'hC000_0000, "R6");                  // A rings itself, R9 readback
    op_b(4'b1000, 32'hC000_0000, "R6");                  // B rings A
    op_a(4'b1000, 32'hA000_0000, "R7");                  // A rings B
    op_b(4'b1000, 32'hA000_0000, "R7");                  // B rings itself
    op(1, 4'b1000, 32'hE000_0000, 1, 4'b1000, 32'hE000_0000, "R11"); // both ring both
    op_a(4'b1000, 32'h8000_0000, "R8");                  // zeros on trigger bits
    op_a(4'b1111, 32'hFFFF_FFFF, "R9");                  // reserved bits stay zero
    op_b(4'b0111, 32'hFFFF_3CFF, "R10");                 // no lane 3: no trigger, enable kept
    op_b(4'b1000, 32'h0000_0000, "R5");                  // disable B
    op_a(4'b1000, 32'hA000_0000, "R8");                  // ring disabled B
    op_a(4'b1000, 32'h4000_0000, "R6");                  // clear A enable while ringing A
    op_b(4'b1000, 32'h4000_0000, "R8");                  // A now disabled
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R1 queue not drained actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule